// File: doc/BRIEF.md
# Video NAL Byte Packetizer with Half-Buffer Double Buffering

The block accepts a video network-abstraction-layer byte stream from an external source. The source presents each byte on a bus together with a valid qualifier, an end-of-unit qualifier and a strobe. The block passes the strobe through a synchronizer and acts on its rising edge. Accepted bytes go into one circular store split into two equal halves. When a half is complete, either because it is full or because a unit ended inside it, that half is offered to a downstream scheduler as one 188-byte transport packet. The block adds the 4-byte header, which carries a fixed packet identifier, as the half is read out. While one half drains, the other half keeps taking input.

A unit start is marked in the header of the first packet that follows reset or an end of unit. A unit that ends part way through a half leaves the rest of that packet's payload as 0xFF. When an instantaneous-decoder-refresh unit arrives and the input has carried no sequence or picture parameter set since the last such unit, the block first writes stored copies of both parameter sets into the stream. When the scheduler falls behind, bytes that have nowhere to go are dropped and a sticky flag records the loss.

Top module: `nal_ts_packetizer`

## Requirements
- R1: After reset, pkt_ready, pkt_valid, pkt_sop, pkt_eop and overflow are all low.
- R2: A byte is taken only on a rising edge of nal_strobe and only while nal_valid is high. It is written SYNC_STAGES+1 clock edges after the first edge that sees the strobe high. A strobe edge with nal_valid low stores nothing.
- R3: When HALF bytes have been written into a half, pkt_ready goes high in the next cycle, provided no packet is being streamed. Later bytes go into the other half.
- R4: A packet is HALF+4 bytes on consecutive cycles, with pkt_sop on the first and pkt_eop on the last. Byte 0 is 0x47. Byte 1 is {0, start flag, 0, PID[12:8]}. Byte 2 is PID[7:0]. Byte 3 is 0x10. pkt_ready is low while a packet streams.
- R5: pkt_take sampled high while pkt_ready is high starts a packet with pkt_sop in the next cycle. pkt_take has no effect while pkt_ready is low.
- R6: A strobe edge with nal_done high ends the unit. If the current half holds at least one byte, it closes at once, and its payload positions past the last written byte read out as 0xFF. If the half is empty, no packet is produced.
- R7: The start flag (bit 6 of header byte 1) is 1 in the packet holding the first byte written after reset or after an end of unit, and 0 in all other packets.
- R8: A byte is dropped when both halves are closed and not yet fully streamed. overflow then goes high and stays high until reset.
- R9: The first byte of a unit carries its type in bits 4:0. If that type is 5 and no unit of type 7 or 8 has started since reset or since the previous type-5 unit, the stored sequence parameter set bytes and then the stored picture parameter set bytes are written, one per cycle, before that first byte.
- R10: A unit of type 7 or 8 starting after the previous type-5 unit suppresses the insertion for the next type-5 unit.
- R11: Halves are offered and streamed in the order in which they were closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nal_byte | input | 8 | Input byte |
| nal_valid | input | 1 | Byte on nal_byte is meaningful |
| nal_done | input | 1 | Current unit ends with this strobe |
| nal_strobe | input | 1 | Rising edge presents a byte event |
| pkt_take | input | 1 | Scheduler accepts the offered packet |
| pkt_ready | output | 1 | A closed half waits to be streamed |
| pkt_valid | output | 1 | pkt_data carries a packet byte |
| pkt_sop | output | 1 | First byte of a packet |
| pkt_eop | output | 1 | Last byte of a packet |
| pkt_data | output | 8 | Packet byte |
| overflow | output | 1 | Sticky: an input byte was dropped |

## Verification
The properties assume a well-behaved source. It holds nal_byte, nal_valid and nal_done steady from the strobe's rise until the synchronized edge has been taken. It keeps each strobe high for at least one cycle and low for at least one cycle. After the first byte of a type-5 unit it raises no new strobe until the parameter-set insertion has finished. The stimulus drives one strobe every four clocks, and it holds the data until the next strobe. After every type-5 first byte it waits the insertion length plus three clocks, so no event ever lands inside an insertion window.

// File: rtl/nal_ts_pkg.sv
package nal_ts_pkg;

   localparam int         HDR_LEN  = 4;
   localparam logic [7:0] TS_SYNC  = 8'h47;
   localparam logic [7:0] TS_FILL  = 8'hFF;
   localparam logic [4:0] NT_IDR   = 5'd5;
   localparam logic [4:0] NT_SEQ   = 5'd7;
   localparam logic [4:0] NT_PIC   = 5'd8;

   // one write request per cycle into the half store
   typedef struct packed {
      logic       wr;
      logic       close;
      logic [7:0] data;
   } wr_item_t;

   // transport header byte i of a payload-only packet, counter left at zero
   function automatic logic [7:0] ts_hdr_byte(input logic [1:0] i,
                                              input logic pusi,
                                              input logic [12:0] pid);
      case (i)
         2'd0:    return TS_SYNC;
         2'd1:    return {1'b0, pusi, 1'b0, pid[12:8]};
         2'd2:    return pid[7:0];
         default: return 8'h10;
      endcase
   endfunction

endpackage

// File: rtl/nal_ts_capture.sv
module nal_ts_capture #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strobe,
   input  logic       valid,
   input  logic       done,
   input  logic [7:0] data_in,
   output logic       fire,
   output logic       has,
   output logic       fin,
   output logic [7:0] data_out
);

   // SYNC_STAGES synchronizer flops plus one history flop
   logic [SYNC_STAGES:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_STAGES-1:0], strobe};
   end

   // R2: act on the synchronized rising edge only
   assign fire     = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
   assign has      = fire & valid;
   assign fin      = fire & done;
   assign data_out = data_in;

endmodule

// File: rtl/nal_ts_psinsert.sv
module nal_ts_psinsert
   import nal_ts_pkg::*;
#(
   parameter bit                    INSERT_EN = 1'b1,
   parameter int                    SPS_LEN   = 4,
   parameter logic [8*SPS_LEN-1:0]  SPS_DATA  = 32'h1E004267,
   parameter int                    PPS_LEN   = 3,
   parameter logic [8*PPS_LEN-1:0]  PPS_DATA  = 24'h38CE68
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fire,
   input  logic       has,
   input  logic       fin,
   input  logic [7:0] data,
   output wr_item_t   item
);

   generate
      if (INSERT_EN) begin : g_ins
         localparam int INS_LEN = SPS_LEN + PPS_LEN;
         localparam int IDX_W   = $clog2(INS_LEN + 1);
         // byte k of the insertion sits at bits [8k +: 8]
         localparam logic [8*INS_LEN-1:0] PS = {PPS_DATA, SPS_DATA};

         logic             at_head, seen, busy, held_fin;
         logic [IDX_W-1:0] idx;
         logic [7:0]       held_byte;
         logic             is_head, want;
         logic [4:0]       ntype;

         assign ntype   = data[4:0];
         assign is_head = has & at_head & ~busy;
         // R9: type-5 head with no parameter set seen since the last one
         assign want    = is_head & (ntype == NT_IDR) & ~seen;

         always_comb begin
            item = '0;
            if (busy) begin
               if (idx == IDX_W'(INS_LEN)) item = '{wr: 1'b1, close: held_fin, data: held_byte};
               else                        item = '{wr: 1'b1, close: 1'b0, data: PS[8*idx +: 8]};
            end else if (want) begin
               item = '{wr: 1'b1, close: 1'b0, data: PS[7:0]};
            end else begin
               item = '{wr: has, close: fin, data: data};
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               at_head   <= 1'b1;
               seen      <= 1'b0;
               busy      <= 1'b0;
               idx       <= '0;
               held_byte <= '0;
               held_fin  <= 1'b0;
            end else begin
               if (busy) begin
                  if (idx == IDX_W'(INS_LEN)) busy <= 1'b0;
                  else                        idx  <= idx + 1'b1;
               end else begin
                  if (want) begin
                     busy      <= 1'b1;
                     idx       <= IDX_W'(1);
                     held_byte <= data;
                     held_fin  <= fin;
                  end
                  if (fire) begin
                     if (fin)      at_head <= 1'b1;
                     else if (has) at_head <= 1'b0;
                  end
                  // R10: a parameter-set unit from the input suppresses insertion
                  if (is_head) begin
                     if (ntype == NT_SEQ || ntype == NT_PIC) seen <= 1'b1;
                     else if (ntype == NT_IDR)               seen <= 1'b0;
                  end
               end
            end
         end
      end else begin : g_pass
         assign item = '{wr: has, close: fin, data: data};
      end
   endgenerate

endmodule

// File: rtl/nal_ts_halfbuf.sv
module nal_ts_halfbuf
   import nal_ts_pkg::*;
#(
   parameter int          HALF = 184,
   parameter logic [12:0] PID  = 13'h0100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  wr_item_t   item,
   input  logic       take,
   output logic       ready,
   output logic       valid,
   output logic       sop,
   output logic       eop,
   output logic [7:0] data,
   output logic       ovf
);

   localparam int PKT   = HALF + HDR_LEN;
   localparam int CNT_W = $clog2(HALF + 1);
   localparam int AW    = $clog2(2 * HALF);
   localparam int IW    = $clog2(PKT);

   logic [7:0]       mem [2*HALF];
   logic             fh, rh, sending, pend;
   logic [1:0]       full, hpusi;
   logic [CNT_W-1:0] fc, fc_nx, pos;
   logic [CNT_W-1:0] len [2];
   logic [IW-1:0]    idx;
   logic             wr_ok, close_now, fin_rd, start_rd;
   logic [AW-1:0]    wr_addr, rd_addr;

   // R8: a byte whose target half is still occupied is dropped
   assign wr_ok     = item.wr & ~full[fh];
   assign fc_nx     = fc + CNT_W'(wr_ok);
   // R3 and R6: close on a full half or on end of unit with data present
   assign close_now = (fc_nx == CNT_W'(HALF)) | (item.close & (fc_nx != '0));
   assign wr_addr   = (fh ? AW'(HALF) : AW'(0)) + AW'(fc);

   assign fin_rd    = sending & (idx == IW'(PKT - 1));
   assign start_rd  = take & full[rh] & ~sending;
   assign pos       = CNT_W'(idx - IW'(HDR_LEN));
   assign rd_addr   = (rh ? AW'(HALF) : AW'(0)) + AW'(pos);

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_addr] <= item.data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fh      <= 1'b0;
         rh      <= 1'b0;
         sending <= 1'b0;
         pend    <= 1'b1;
         full    <= '0;
         hpusi   <= '0;
         fc      <= '0;
         len[0]  <= '0;
         len[1]  <= '0;
         idx     <= '0;
         ovf     <= 1'b0;
      end else begin
         // R5 and R11: strictly alternate halves on readout
         if (start_rd) begin
            sending <= 1'b1;
            idx     <= '0;
         end else if (sending) begin
            if (fin_rd) begin
               sending  <= 1'b0;
               rh       <= ~rh;
               full[rh] <= 1'b0;
            end else begin
               idx <= idx + 1'b1;
            end
         end
         // R7: the first byte written after a unit end marks its half
         if (wr_ok && fc == '0) hpusi[fh] <= pend;
         if (item.close)                pend <= 1'b1;
         else if (wr_ok && fc == '0)    pend <= 1'b0;
         if (item.wr && full[fh]) ovf <= 1'b1;
         if (close_now) begin
            full[fh] <= 1'b1;
            len[fh]  <= fc_nx;
            fh       <= ~fh;
            fc       <= '0;
         end else begin
            fc <= fc_nx;
         end
      end
   end

   // R4 and R6: header added on the fly, unwritten payload reads as fill
   always_comb begin
      data = TS_FILL;
      if (idx < IW'(HDR_LEN))  data = ts_hdr_byte(idx[1:0], hpusi[rh], PID);
      else if (pos < len[rh])  data = mem[rd_addr];
   end

   assign ready = full[rh] & ~sending;
   assign valid = sending;
   assign sop   = sending & (idx == '0);
   assign eop   = fin_rd;

endmodule

// File: rtl/nal_ts_packetizer.sv
module nal_ts_packetizer
   import nal_ts_pkg::*;
#(
   parameter int                    HALF        = 184,
   parameter logic [12:0]           PID         = 13'h0100,
   parameter int                    SYNC_STAGES = 2,
   parameter bit                    INSERT_EN   = 1'b1,
   parameter int                    SPS_LEN     = 4,
   parameter logic [8*SPS_LEN-1:0]  SPS_DATA    = 32'h1E004267,
   parameter int                    PPS_LEN     = 3,
   parameter logic [8*PPS_LEN-1:0]  PPS_DATA    = 24'h38CE68
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] nal_byte,
   input  logic       nal_valid,
   input  logic       nal_done,
   input  logic       nal_strobe,
   input  logic       pkt_take,
   output logic       pkt_ready,
   output logic       pkt_valid,
   output logic       pkt_sop,
   output logic       pkt_eop,
   output logic [7:0] pkt_data,
   output logic       overflow
);

   generate
      if (HALF < 1) begin : g_bad_half
         $error("HALF must be at least 1");
      end
      if (PID == 13'h1FFF) begin : g_bad_pid
         $error("PID 0x1FFF is reserved for null packets");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (INSERT_EN && (SPS_LEN < 1 || PPS_LEN < 1)) begin : g_bad_ps
         $error("stored parameter sets must be non-empty");
      end
   endgenerate

   logic       ev_fire, ev_has, ev_fin;
   logic [7:0] ev_data;
   wr_item_t   item;

   nal_ts_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (nal_strobe),
      .valid    (nal_valid),
      .done     (nal_done),
      .data_in  (nal_byte),
      .fire     (ev_fire),
      .has      (ev_has),
      .fin      (ev_fin),
      .data_out (ev_data)
   );

   nal_ts_psinsert #(
      .INSERT_EN (INSERT_EN),
      .SPS_LEN   (SPS_LEN),
      .SPS_DATA  (SPS_DATA),
      .PPS_LEN   (PPS_LEN),
      .PPS_DATA  (PPS_DATA)
   ) u_ins (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (ev_fire),
      .has   (ev_has),
      .fin   (ev_fin),
      .data  (ev_data),
      .item  (item)
   );

   nal_ts_halfbuf #(.HALF(HALF), .PID(PID)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .item  (item),
      .take  (pkt_take),
      .ready (pkt_ready),
      .valid (pkt_valid),
      .sop   (pkt_sop),
      .eop   (pkt_eop),
      .data  (pkt_data),
      .ovf   (overflow)
   );

endmodule

// File: rtl/nal_ts_packetizer_chk.sv
module nal_ts_packetizer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pkt_take,
   input logic       pkt_ready,
   input logic       pkt_valid,
   input logic       pkt_sop,
   input logic       pkt_eop,
   input logic [7:0] pkt_data,
   input logic       overflow
);

   // R4
   ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_ready |-> !pkt_valid);

   // R4
   sop_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_sop |-> (pkt_valid && pkt_data == 8'h47));

   // R4
   stream_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && !pkt_eop) |=> pkt_valid);

   // R4
   eop_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_eop |=> !pkt_valid);

   // R4
   sop_eop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pkt_sop, pkt_eop}));

   // R5
   take_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_take && pkt_ready) |=> pkt_sop);

   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

endmodule

bind nal_ts_packetizer nal_ts_packetizer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pkt_take  (pkt_take),
   .pkt_ready (pkt_ready),
   .pkt_valid (pkt_valid),
   .pkt_sop   (pkt_sop),
   .pkt_eop   (pkt_eop),
   .pkt_data  (pkt_data),
   .overflow  (overflow)
);

// File: tb/nal_ts_packetizer_bench.sv
module nal_ts_packetizer_bench;

   localparam int          HALF = 12;
   localparam int          PKT  = HALF + 4;
   localparam int          SYNC = 2;
   localparam int          INS  = 7;
   localparam logic [12:0] PID  = 13'h0101;

   logic       clk, rst_n;
   logic [7:0] nal_byte;
   logic       nal_valid, nal_done, nal_strobe, pkt_take;
   logic       pkt_ready, pkt_valid, pkt_sop, pkt_eop, overflow;
   logic [7:0] pkt_data;

   nal_ts_packetizer #(
      .HALF(HALF), .PID(PID), .SYNC_STAGES(SYNC), .INSERT_EN(1'b1),
      .SPS_LEN(4), .SPS_DATA(32'h1E004267), .PPS_LEN(3), .PPS_DATA(24'h38CE68)
   ) u_nal_ts_packetizer (
      .clk(clk), .rst_n(rst_n), .nal_byte(nal_byte), .nal_valid(nal_valid),
      .nal_done(nal_done), .nal_strobe(nal_strobe), .pkt_take(pkt_take),
      .pkt_ready(pkt_ready), .pkt_valid(pkt_valid), .pkt_sop(pkt_sop),
      .pkt_eop(pkt_eop), .pkt_data(pkt_data), .overflow(overflow)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   // stored parameter sets in insertion order
   byte unsigned ps_tab [INS] = '{8'h67, 8'h42, 8'h00, 8'h1E, 8'h68, 8'hCE, 8'h38};

   // behavioural reference state
   int           q[$];
   byte unsigned cur[$];
   byte unsigned pay[$];
   bit           pus[$];
   bit [SYNC:0]  mh;
   bit           at_head, seen, pend, movf, m_send, cur_p;
   int           m_idx;

   int    checks, fails, sops;
   string tag;
   bit    finished;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int hdr(int i, bit p);
      case (i)
         0: return 8'h47;
         1: return {1'b0, p, 1'b0, PID[12:8]};
         2: return PID[7:0];
         default: return 8'h10;
      endcase
   endfunction

   task automatic model_reset();
      q.delete(); cur.delete(); pay.delete(); pus.delete();
      mh = '0; at_head = 1; seen = 0; pend = 1; movf = 0;
      m_send = 0; m_idx = 0; cur_p = 0;
   endtask

   task automatic model_step();
      bit m_edge, cl;
      int cnt_pre, it, t;
      if (!rst_n) begin
         model_reset();
         return;
      end
      m_edge = mh[SYNC-1] && !mh[SYNC];
      mh = {mh[SYNC-1:0], nal_strobe};
      if (m_edge) begin
         if (nal_valid && at_head) begin
            t = nal_byte & 31;
            if (t == 5 && !seen) begin
               for (int k = 0; k < INS; k++) q.push_back(256 | ps_tab[k]);
            end else if (t == 5) seen = 0;
            else if (t == 7 || t == 8) seen = 1;
         end
         it = (nal_valid ? (256 | nal_byte) : 0) | (nal_done ? 512 : 0);
         if (it != 0) q.push_back(it);
         if (nal_done) at_head = 1;
         else if (nal_valid) at_head = 0;
      end
      cnt_pre = pus.size();
      if (m_send) begin
         if (m_idx == PKT - 1) begin
            m_send = 0;
            for (int k = 0; k < HALF; k++) void'(pay.pop_front());
            void'(pus.pop_front());
         end else m_idx++;
      end else if (pkt_take && cnt_pre > 0) begin
         m_send = 1;
         m_idx  = 0;
      end
      if (q.size() > 0) begin
         it = q.pop_front();
         if ((it & 256) != 0) begin
            if (cnt_pre == 2) movf = 1;
            else begin
               if (cur.size() == 0) begin cur_p = pend; pend = 0; end
               cur.push_back(it & 255);
            end
         end
         cl = (cur.size() == HALF) || (((it & 512) != 0) && cur.size() > 0);
         if (cl) begin
            while (cur.size() < HALF) cur.push_back(8'hFF);
            foreach (cur[k]) pay.push_back(cur[k]);
            pus.push_back(cur_p);
            cur.delete();
         end
         if ((it & 512) != 0) pend = 1;
      end
   endtask

   task automatic compare();
      chk("R3", "ready", pkt_ready, (pus.size() > 0 && !m_send));
      chk("R4", "valid", pkt_valid, m_send);
      chk("R4", "sop", pkt_sop, m_send && m_idx == 0);
      chk("R4", "eop", pkt_eop, m_send && m_idx == PKT - 1);
      chk("R8", "overflow", overflow, movf);
      if (m_send) begin
         if (m_idx == 1)     chk("R7", "start flag byte", pkt_data, hdr(1, pus[0]));
         else if (m_idx < 4) chk("R4", "header byte", pkt_data, hdr(m_idx, pus[0]));
         else                chk(tag, "payload", pkt_data, pay[m_idx-4]);
      end
      if (pkt_sop) sops++;
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic send(input logic [7:0] b, input bit v, input bit d, input int gap);
      nal_byte = b; nal_valid = v; nal_done = d; nal_strobe = 1'b1;
      tick();
      nal_strobe = 1'b0;
      repeat (gap) tick();
   endtask

   task automatic unit(input logic [7:0] head, input int n);
      send(head, 1, 0, (head[4:0] == 5) ? INS + 3 : 3);
      for (int i = 1; i < n; i++) send(8'(i * 7 + 3), 1, (i == n - 1), 3);
   endtask

   initial begin
      checks = 0; fails = 0; sops = 0; finished = 0; tag = "R2";
      rst_n = 0; nal_byte = 0; nal_valid = 0; nal_done = 0; nal_strobe = 0; pkt_take = 0;
      model_reset();
      repeat (3) tick();
      // R1
      chk("R1", "reset ready", pkt_ready, 0);
      chk("R1", "reset valid", pkt_valid, 0);
      chk("R1", "reset sop/eop", {pkt_sop, pkt_eop}, 0);
      chk("R1", "reset overflow", overflow, 0);
      rst_n = 1;
      tick();

      // R2 R3 R11: long unit crossing several halves, one invalid strobe inside
      tag = "R2"; pkt_take = 1;
      send(8'h41, 1, 0, 3);
      for (int i = 1; i < 2 * HALF + 2; i++) begin
         send(8'(i), 1, 0, 3);
         if (i == 5) send(8'hEE, 0, 0, 3);
      end
      send(8'h55, 1, 1, 3);
      repeat (40) tick();

      // R6: exact half then a bare end, then a short padded unit
      tag = "R6"; sops = 0;
      send(8'h41, 1, 0, 3);
      for (int i = 1; i < HALF; i++) send(8'(i + 100), 1, 0, 3);
      send(8'h00, 0, 1, 3);
      repeat (30) tick();
      unit(8'h41, 3);
      repeat (30) tick();
      chk("R6", "packets from full half, bare end, short unit", sops, 2);

      // R9: type-5 unit with no parameter set yet
      tag = "R9";
      unit(8'h65, 6);
      repeat (40) tick();

      // R10: input carries both parameter sets, so the next type-5 unit is plain
      tag = "R10";
      unit(8'h67, 3);
      unit(8'h68, 2);
      unit(8'h65, 4);
      repeat (40) tick();
      unit(8'h65, 4);
      repeat (40) tick();

      // R8 R5 R11: scheduler stalls, both halves fill, extra bytes drop
      tag = "R8"; pkt_take = 0;
      send(8'h41, 1, 0, 3);
      for (int i = 1; i < 2 * HALF + 4; i++) send(8'(i + 50), 1, 0, 3);
      repeat (5) tick();
      chk("R8", "overflow after stall", overflow, 1);
      chk("R5", "no stream without take", pkt_valid, 0);
      chk("R5", "packet offered", pkt_ready, 1);
      tag = "R11"; pkt_take = 1;
      repeat (60) tick();
      chk("R8", "overflow stays set", overflow, 1);
      chk("R11", "both halves drained", pkt_ready, 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL R4 watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule